// File: doc/BRIEF.md
# Byte-wide Nonvolatile Store Access Controller

This block sits between a small register port on the CPU side and a 512-byte nonvolatile data array. The array has its own address space, separate from data memory. Software fills three registers: a split address, a data byte and a control byte. Then it sets a strobe in the control byte to read or write one byte. While an access is being set up, the block holds the CPU with a stall output for a fixed number of cycles. The stall lasts longer for a read than for a write.

Writes are guarded. The write strobe takes effect only if an arming bit was set shortly before it. Once accepted, a write completes in the background over a fixed, parameterised number of cycles. During that time a busy flag is visible to software. Every strobe that arrives while busy is dropped. An optional interrupt line reports that the store is idle.

Top module: `nvm_access_ctrl`

## Requirements
- R1: Every one of the 512 byte locations stores the byte last written to it, independently of the others. The 9-bit location index is formed from the low address register (select 0) as bits 7..0 and bit 0 of the high address register (select 1) as bit 8.
- R2: Reading the high address register returns its bit 0 in bit 0, and zero in bits 7..1, whatever was written there.
- R3: A control write (select 3) with the read strobe (bit 0) set and the write strobe (bit 1) clear, while idle, drives cpu_stall high for exactly 4 cycles, starting in the cycle after that write.
- R4: An accepted write request drives cpu_stall high for exactly 2 cycles, starting in the cycle after the control write.
- R5: Setting the arm bit (control bit 2) opens a window of 4 clock edges. A write strobe written on any of those edges is accepted, and the arm bit then reads back as 0. A write strobe written on the 5th edge or later is ignored.
- R6: A write strobe with no earlier open arm window is ignored. This includes a strobe written together with the arm bit. The busy flag stays 0 and the array is not changed.
- R7: After an accepted write, the busy flag (control bit 4) reads 1 for exactly WRITE_CYCLES (default 64) cycles. At the end of that period the buffered byte is stored at the buffered location.
- R8: While busy, read and write strobes are ignored. No stall is raised, the data register is left unchanged and the array is left unchanged.
- R9: At the end of a read stall, the data register (select 2) holds the byte stored at the addressed location.
- R10: irq is high exactly when the interrupt-enable bit (control bit 3) is set and busy is 0.
- R11: After reset, cpu_stall, irq, busy, arm, interrupt enable, both address registers and the data register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 address low, 1 address high, 2 data, 3 control |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the selected register |
| cpu_stall | output | 1 | Holds the CPU while an access is being set up |
| irq | output | 1 | Idle interrupt, gated by the enable bit |

## Verification
A control write is sampled on edge t. Stall and busy are registered, so both first read high in the cycle after edge t. The bench counts the cycles in which they stay high, sampling at falling edges, and expects 4 for a read, 2 for a write and WRITE_CYCLES for busy. Read data is taken from the array on the edge after the request and passes into the data register one edge later, so the bench reads it only once stall has dropped. The arm window is probed by placing the write strobe 4 and then 5 edges after the arm edge. Each check is made in the falling-edge half-cycle that follows the edge it depends on.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } nvm_sel_e;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_ARM  = 2;
  localparam int CB_IE   = 3;
  localparam int CB_BUSY = 4;
endpackage

// File: rtl/nvm_arm_guard.sv
module nvm_arm_guard #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_req,
  input  logic consume,
  output logic armed
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] win_cnt;

  always_ff @(posedge clk) begin
    if (rst)                win_cnt <= '0;
    else if (consume)       win_cnt <= '0;
    else if (arm_req)       win_cnt <= CW'(WINDOW);
    else if (win_cnt != '0) win_cnt <= win_cnt - 1'b1;
  end

  assign armed = (win_cnt != '0);

  // R5
  window_bound_chk: assert property (@(posedge clk) disable iff (rst)
    win_cnt <= CW'(WINDOW));

  // R6
  arm_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(arm_req));
endmodule

// File: rtl/nvm_timer_seq.sv
module nvm_timer_seq #(
  parameter int READ_STALL   = 4,
  parameter int WRITE_STALL  = 2,
  parameter int WRITE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_go,
  input  logic wr_go,
  output logic stall,
  output logic busy,
  output logic commit
);
  localparam int MAX_STALL = (READ_STALL > WRITE_STALL) ? READ_STALL : WRITE_STALL;
  localparam int SW = $clog2(MAX_STALL + 1);
  localparam int BW = $clog2(WRITE_CYCLES + 1);

  logic [SW-1:0] stall_cnt;
  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  stall_cnt <= '0;
    else if (wr_go)           stall_cnt <= SW'(WRITE_STALL);
    else if (rd_go)           stall_cnt <= SW'(READ_STALL);
    else if (stall_cnt != '0) stall_cnt <= stall_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 busy_cnt <= '0;
    else if (wr_go)          busy_cnt <= BW'(WRITE_CYCLES);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end

  assign stall  = (stall_cnt != '0);
  assign busy   = (busy_cnt != '0);
  assign commit = (busy_cnt == BW'(1));

  // R3
  read_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> stall);

  // R4
  write_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> (stall && busy));

  // R7
  commit_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(commit));
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rq,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= cells[raddr];
  end

  // R8
  port_excl_chk: assert property (@(posedge clk) !(re && we));
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl #(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int READ_STALL   = 4,
  parameter int WRITE_STALL  = 2,
  parameter int WRITE_CYCLES = 64,
  parameter int ARM_WINDOW   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cpu_stall,
  output logic              irq
);
  import nvm_pkg::*;

  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] addr_lo;
  logic [HI_W-1:0]   addr_hi;
  logic [DATA_W-1:0] data_q;
  logic              ie_q;
  logic              rd_pend;
  logic [ADDR_W-1:0] wbuf_addr;
  logic [DATA_W-1:0] wbuf_data;
  logic [DATA_W-1:0] arr_q;

  logic ctrl_wr, armed, stall, busy, commit, idle, wr_go, rd_go, arm_req;

  assign ctrl_wr = reg_we && (reg_sel == SEL_CTRL);
  assign idle    = !busy && !stall;
  assign wr_go   = ctrl_wr && reg_wdata[CB_WR] && armed && idle;
  assign rd_go   = ctrl_wr && reg_wdata[CB_RD] && !reg_wdata[CB_WR] && idle;
  assign arm_req = ctrl_wr && reg_wdata[CB_ARM];

  nvm_arm_guard #(.WINDOW(ARM_WINDOW)) u_guard (
    .clk(clk), .rst(rst), .arm_req(arm_req), .consume(wr_go), .armed(armed)
  );

  nvm_timer_seq #(
    .READ_STALL(READ_STALL), .WRITE_STALL(WRITE_STALL), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .rd_go(rd_go), .wr_go(wr_go),
    .stall(stall), .busy(busy), .commit(commit)
  );

  nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .re(rd_go), .raddr({addr_hi, addr_lo}), .rq(arr_q),
    .we(commit), .waddr(wbuf_addr), .wdata(wbuf_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo <= '0;
      addr_hi <= '0;
      ie_q    <= 1'b0;
      rd_pend <= 1'b0;
      data_q  <= '0;
    end else begin
      rd_pend <= rd_go;
      if (reg_we && reg_sel == SEL_ADDR_LO) addr_lo <= reg_wdata;
      if (reg_we && reg_sel == SEL_ADDR_HI) addr_hi <= reg_wdata[HI_W-1:0];
      if (ctrl_wr) ie_q <= reg_wdata[CB_IE];
      if (rd_pend) data_q <= arr_q;
      else if (reg_we && reg_sel == SEL_DATA) data_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      wbuf_addr <= {addr_hi, addr_lo};
      wbuf_data <= data_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR_LO: reg_rdata = addr_lo;
      SEL_ADDR_HI: reg_rdata[HI_W-1:0] = addr_hi;
      SEL_DATA:    reg_rdata = data_q;
      default: begin
        reg_rdata[CB_BUSY] = busy;
        reg_rdata[CB_IE]   = ie_q;
        reg_rdata[CB_ARM]  = armed;
      end
    endcase
  end

  assign cpu_stall = stall;
  assign irq       = ie_q && !busy;

  // R9
  read_load_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pend |-> cpu_stall);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr) |=> !$rose(cpu_stall));
endmodule

// File: tb/test_nvm_access_ctrl.sv
module test_nvm_access_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cpu_stall, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic ie   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nvm_access_ctrl i_nvm_access_ctrl (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_stall(cpu_stall), .irq(irq)
  );

  localparam logic [16:0] VEC [6] = '{
    {9'd0,   8'hA5}, {9'd511, 8'h3C}, {9'd256, 8'hFF},
    {9'd255, 8'h00}, {9'd1,   8'h5A}, {9'd300, 8'h81}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  function automatic logic [7:0] ctl(input bit rs, input bit ws, input bit arm);
    return {4'b0, ie, arm, ws, rs};
  endfunction

  task automatic set_addr(input logic [8:0] a);
    wr(2'd0, a[7:0]);
    wr(2'd1, {7'b0, a[8]});
  endtask

  task automatic busy_now(output bit b);
    logic [7:0] v;
    peek(2'd3, v); b = v[4];
  endtask

  task automatic wait_idle();
    bit b;
    busy_now(b);
    for (int i = 0; i < 500 && b; i++) begin
      @(negedge clk); busy_now(b);
    end
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (cpu_stall && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic do_read(input logic [8:0] a, output logic [7:0] d, output int ns);
    set_addr(a);
    wr(2'd3, ctl(1, 0, 0));
    count_stall(ns);
    peek(2'd2, d);
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] d,
                          output int ns, output int nb);
    bit b;
    set_addr(a);
    wr(2'd2, d);
    wr(2'd3, ctl(0, 0, 1));
    wr(2'd3, ctl(0, 1, 0));
    ns = 0; nb = 0;
    busy_now(b);
    while (b && nb < 500) begin
      if (cpu_stall) ns++;
      nb++;
      @(negedge clk); busy_now(b);
    end
  endtask

  initial begin
    logic [7:0] v;
    int ns, nb;
    bit b;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 stall", cpu_stall, 0);
    check("R11 irq", irq, 0);
    peek(2'd3, v); check("R11 ctrl", v, 0);
    peek(2'd0, v); check("R11 addr_lo", v, 0);
    peek(2'd1, v); check("R11 addr_hi", v, 0);
    peek(2'd2, v); check("R11 data", v, 0);

    // R2 high address readback
    wr(2'd1, 8'hFF);
    peek(2'd1, v); check("R2 hi readback", v, 8'h01);
    wr(2'd1, 8'hFE);
    peek(2'd1, v); check("R2 hi readback even", v, 8'h00);

    // Vector table: write, then read back (R1 R4 R7 R3 R9)
    foreach (VEC[i]) begin
      do_write(VEC[i][16:8], VEC[i][7:0], ns, nb);
      check("R4 write stall", ns, 2);
      check("R7 busy length", nb, WCYC);
    end
    foreach (VEC[i]) begin
      wr(2'd2, ~VEC[i][7:0]);
      do_read(VEC[i][16:8], v, ns);
      check("R3 read stall", ns, 4);
      check("R1 R9 read data", v, VEC[i][7:0]);
    end

    // R5 window: strobe 4 edges after arm accepted, arm then reads 0
    set_addr(9'd10); wr(2'd2, 8'h11);
    wr(2'd3, ctl(0, 0, 1));
    peek(2'd3, v); check("R5 arm set", v[2], 1);
    repeat (3) @(negedge clk);
    wr(2'd3, ctl(0, 1, 0));
    peek(2'd3, v);
    check("R5 4th edge accepted", v[4], 1);
    check("R5 arm cleared", v[2], 0);
    wait_idle();
    // R5 strobe on 5th edge ignored
    wr(2'd2, 8'h22);
    wr(2'd3, ctl(0, 0, 1));
    repeat (4) @(negedge clk);
    wr(2'd3, ctl(0, 1, 0));
    busy_now(b); check("R5 5th edge ignored", b, 0);
    do_read(9'd10, v, ns); check("R5 array kept", v, 8'h11);

    // R6 unarmed strobe, and strobe together with arm
    wr(2'd2, 8'h33);
    wr(2'd3, ctl(0, 1, 0));
    busy_now(b); check("R6 lone strobe busy", b, 0);
    wr(2'd3, ctl(0, 1, 1));
    busy_now(b); check("R6 strobe with arm busy", b, 0);
    repeat (6) @(negedge clk);
    do_read(9'd10, v, ns); check("R6 array kept", v, 8'h11);

    // R8 strobes while busy
    set_addr(9'd20); wr(2'd2, 8'h44);
    wr(2'd3, ctl(0, 0, 1));
    wr(2'd3, ctl(0, 1, 0));
    wr(2'd2, 8'h77);
    wr(2'd3, ctl(1, 0, 0));
    check("R8 read ignored stall", cpu_stall, 0);
    repeat (5) @(negedge clk);
    peek(2'd2, v); check("R8 data kept", v, 8'h77);
    set_addr(9'd21);
    wr(2'd3, ctl(0, 0, 1));
    wr(2'd3, ctl(0, 1, 0));
    wait_idle();
    do_read(9'd21, v, ns); check("R8 write ignored", v, 8'h81 & 8'h00);
    do_read(9'd20, v, ns); check("R7 committed", v, 8'h44);

    // R10 irq
    ie = 1'b1;
    wr(2'd3, ctl(0, 0, 0));
    check("R10 irq idle", irq, 1);
    wr(2'd2, 8'h99);
    set_addr(9'd22);
    wr(2'd3, ctl(0, 0, 1));
    wr(2'd3, ctl(0, 1, 0));
    check("R10 irq busy", irq, 0);
    wait_idle();
    check("R10 irq after", irq, 1);
    ie = 1'b0;
    wr(2'd3, ctl(0, 0, 0));
    check("R10 irq disabled", irq, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule